// File: doc/BRIEF.md
# Odd/Even Pixel Merger with Region Tagging

This block sits behind the analogue front end of a three-colour line sensor whose every colour is read out on two channels: one carrying the odd pixels of a line, the other carrying the even pixels. The block receives one digitised sample pair per colour per transfer beat and turns each pair into two consecutive output beats, odd pixel first. The result is a single pixel stream per colour in natural line order. All three colours share one timing, so one valid, one tag and one index serve the three pixel lanes together.

Every output pixel carries a region tag (dummy, optical black or effective) and, for effective pixels, a zero-based index. Start-of-line and end-of-line strobes mark the first and last effective pixels. Alongside the stream, the block sums a fixed window of black reference samples on each of the six channels. When a line completes, it publishes the rounded average of each channel. A line that is cut short by the next line start raises a one-cycle error and leaves the published averages untouched.

Top module: `oe_merge`

## Requirements
- R1: A pair is accepted on a clock edge where `pair_valid` is high. For pair number p, the cycle after acceptance shows line position 2p-1 (the odd sample) with `pix_valid` high, and the following cycle shows position 2p (the even sample). Pairs arrive at least two cycles apart; at exactly two cycles apart, the output stream has no gaps.
- R2: Every bus that carries three colours packs red in bits [11:0], green in bits [23:12] and blue in bits [35:24]. `pix_data` holds the odd input of the pair on the odd beat and the even input on the even beat.
- R3: `pix_tag` is 0 (dummy) for positions 1 to 24 and 67 to 90, 1 (optical black) for positions 25 to 66, and 2 (effective) for positions 91 to 5090. The value 3 never appears.
- R4: `pix_idx` equals position minus 91 on effective pixels, giving 0 to 4999. It is 0 on all other pixels.
- R5: `pix_sol` is high only on the beat showing position 91, and `pix_eol` only on the beat showing position 5090. Both are low whenever `pix_valid` is low.
- R6: A pair with `line_first` high starts a line as pair 1. Up to pair 2545, each later pair takes the next number. A pair that arrives outside an open line produces no output, whether no line has started yet or the current line has already reached 2545 pairs.
- R7: For each channel, the black average is the sum of pairs 12 to 36 divided by 25 and rounded to nearest. On the odd channels these pairs hold positions 23 to 71; on the even channels they hold positions 24 to 72. `blk_odd` and `blk_even` use the R2 colour packing.
- R8: `blk_odd` and `blk_even` change only on the edge that accepts pair 2545 of a line. They hold at all other times.
- R9: A `line_first` pair that arrives while the current line has fewer than 2545 pairs raises `line_err` for exactly the next cycle. The averages are not updated, and summing restarts for the new line.
- R10: While reset is held and right after it, `pix_valid`, `pix_sol`, `pix_eol` and `line_err` are 0, and all averages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pair_valid | input | 1 | A sample pair is present on the inputs |
| line_first | input | 1 | The present pair is pair 1 of a new line |
| odd_in | input | 36 | Odd-channel samples, three colours |
| even_in | input | 36 | Even-channel samples, three colours |
| pix_valid | output | 1 | Output beat present |
| pix_data | output | 36 | Merged pixel, three colours |
| pix_tag | output | 2 | Region: 0 dummy, 1 black, 2 effective |
| pix_idx | output | 13 | Effective pixel index |
| pix_sol | output | 1 | First effective pixel |
| pix_eol | output | 1 | Last effective pixel |
| blk_odd | output | 36 | Odd-channel black averages |
| blk_even | output | 36 | Even-channel black averages |
| line_err | output | 1 | Short line detected |

## Verification
The bench drives full lines under four input patterns, each aimed at a different fault:
- Lines with pairs exactly two cycles apart show whether the odd/even handover leaves gaps or swaps order.
- Lines with an extra idle cycle after every third pair show that `pix_valid` drops between pairs, and that positions still follow the pair count rather than time.
- Sample values that differ per colour, per channel and per position expose lane swaps, off-by-one window edges and rounding faults. An all-ones line checks that the average does not overflow.
- Stray pairs before any line and after a completed line, and a line cut at 1000 pairs, separate correct ignoring and short-line handling from averages that are published too early or not held.

// File: rtl/oe_merge.sv
module oe_merge #(
  parameter int W         = 12,
  parameter int LEAD      = 24,
  parameter int BLACK     = 42,
  parameter int TRAIL     = 24,
  parameter int ACTIVE    = 5000,
  parameter int WIN_PAIR0 = 12,
  parameter int WIN_N     = 25,
  parameter int RSHIFT    = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pair_valid,
  input  logic           line_first,
  input  logic [3*W-1:0] odd_in,
  input  logic [3*W-1:0] even_in,
  output logic           pix_valid,
  output logic [3*W-1:0] pix_data,
  output logic [1:0]     pix_tag,
  output logic [$clog2(ACTIVE)-1:0] pix_idx,
  output logic           pix_sol,
  output logic           pix_eol,
  output logic [3*W-1:0] blk_odd,
  output logic [3*W-1:0] blk_even,
  output logic           line_err
);
  localparam int TOTAL = LEAD + BLACK + TRAIL + ACTIVE;
  localparam int PAIRS = TOTAL / 2;
  localparam int PW    = $clog2(TOTAL + 1);
  localparam int IW    = $clog2(ACTIVE);
  localparam int AW    = W + $clog2(WIN_N + 1);
  localparam int PRW   = AW + RSHIFT + 1;
  localparam int RECIP = ((1 << RSHIFT) + WIN_N / 2) / WIN_N;

  localparam logic [PW-1:0] P_BLK0  = PW'(LEAD + 1);
  localparam logic [PW-1:0] P_BLK1  = PW'(LEAD + BLACK);
  localparam logic [PW-1:0] P_EFF0  = PW'(LEAD + BLACK + TRAIL + 1);
  localparam logic [PW-1:0] P_LAST  = PW'(TOTAL);
  localparam logic [PW-1:0] N_LAST  = PW'(PAIRS);
  localparam logic [PW-1:0] N_WLO   = PW'(WIN_PAIR0);
  localparam logic [PW-1:0] N_WHI   = PW'(WIN_PAIR0 + WIN_N - 1);
  localparam logic [PRW-1:0] HALF   = PRW'(1) << (RSHIFT - 1);

  function automatic logic [W-1:0] rnd_avg(input logic [AW-1:0] s);
    logic [PRW-1:0] p;
    p = PRW'(s) * PRW'(RECIP) + HALF;
    return W'(p >> RSHIFT);
  endfunction

  logic [PW-1:0]  pcnt, hpair;
  logic           open_q, vld, sel;
  logic [3*W-1:0] hodd, heven;

  wire           take   = pair_valid && (line_first || open_q);
  wire [PW-1:0]  nidx   = line_first ? PW'(1) : pcnt + PW'(1);
  wire           in_win = (nidx >= N_WLO) && (nidx <= N_WHI);
  wire           fin    = take && (nidx == N_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      hpair    <= '0;
      open_q   <= 1'b0;
      vld      <= 1'b0;
      sel      <= 1'b0;
      hodd     <= '0;
      heven    <= '0;
      line_err <= 1'b0;
    end else begin
      line_err <= pair_valid && line_first && open_q;
      if (take) begin
        pcnt   <= nidx;
        hpair  <= nidx;
        hodd   <= odd_in;
        heven  <= even_in;
        open_q <= (nidx != N_LAST);
        vld    <= 1'b1;
        sel    <= 1'b0;
      end else if (vld) begin
        vld <= !sel;
        sel <= !sel;
      end
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_col
    logic [AW-1:0] acc_o, acc_e;
    logic [W-1:0]  avg_o, avg_e;
    wire  [W-1:0]  so = odd_in[c*W +: W];
    wire  [W-1:0]  se = even_in[c*W +: W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_o <= '0;
        acc_e <= '0;
        avg_o <= '0;
        avg_e <= '0;
      end else if (take) begin
        acc_o <= (line_first ? '0 : acc_o) + (in_win ? AW'(so) : '0);
        acc_e <= (line_first ? '0 : acc_e) + (in_win ? AW'(se) : '0);
        if (fin) begin
          avg_o <= rnd_avg(acc_o);
          avg_e <= rnd_avg(acc_e);
        end
      end
    end

    assign blk_odd[c*W +: W]  = avg_o;
    assign blk_even[c*W +: W] = avg_e;
  end

  wire [PW-1:0] pos = (hpair << 1) - PW'(!sel);
  wire is_eff = pos >= P_EFF0;
  wire is_blk = (pos >= P_BLK0) && (pos <= P_BLK1);

  assign pix_valid = vld;
  assign pix_data  = sel ? heven : hodd;
  assign pix_tag   = is_eff ? 2'd2 : (is_blk ? 2'd1 : 2'd0);
  assign pix_idx   = is_eff ? IW'(pos - P_EFF0) : '0;
  assign pix_sol   = vld && (pos == P_EFF0);
  assign pix_eol   = vld && (pos == P_LAST);
endmodule

module oe_merge_chk #(
  parameter int W      = 12,
  parameter int ACTIVE = 5000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pair_valid,
  input logic           line_first,
  input logic           pix_valid,
  input logic [1:0]     pix_tag,
  input logic [$clog2(ACTIVE)-1:0] pix_idx,
  input logic           pix_sol,
  input logic           pix_eol,
  input logic [3*W-1:0] blk_odd,
  input logic [3*W-1:0] blk_even,
  input logic           line_err
);
  localparam int IW = $clog2(ACTIVE);

  a_r1_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);
  a_r3_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_tag != 2'd3);
  a_r4_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_tag != 2'd2) |-> pix_idx == '0);
  a_r5_sol_next: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |=> pix_valid && pix_tag == 2'd2 && pix_idx == IW'(1));
  a_r5_eol_last: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> pix_valid && pix_tag == 2'd2 && pix_idx == IW'(ACTIVE - 1));
  a_r8_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(blk_odd) || !$stable(blk_even)) |-> $past(pair_valid) && !$past(line_first));
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> $past(pair_valid && line_first));
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> !line_err);
endmodule

bind oe_merge oe_merge_chk #(.W(W), .ACTIVE(ACTIVE)) u_chk (.*);

// File: tb/oe_merge_tb.sv
module oe_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_valid = 1'b0;
  logic        line_first = 1'b0;
  logic [35:0] odd_in = '0, even_in = '0;
  logic        pix_valid, pix_sol, pix_eol, line_err;
  logic [35:0] pix_data, blk_odd, blk_even;
  logic [1:0]  pix_tag;
  logic [12:0] pix_idx;

  always #2.5 clk = ~clk;

  oe_merge u_dut (.*);

  int total = 0, bad = 0, cyc = 0, err_cnt = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] smp(int seed, int c, int par, int p);
    if (seed == 99) return 12'hFFF;
    return 12'((p * 37 + c * 911 + par * 173 + seed * 1237 + (p * p) % 97) % 4096);
  endfunction

  // reference model
  int          m_pcnt, m_sum[6], m_avg[6], idx;
  bit          m_open, m_err;
  int          qpos[$];
  logic [35:0] qdat[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pcnt = 0; m_open = 0; m_err = 0;
      qpos.delete(); qdat.delete();
      for (int k = 0; k < 6; k++) begin m_sum[k] = 0; m_avg[k] = 0; end
    end else begin
      m_err = pair_valid && line_first && m_open;
      if (qpos.size() > 0) begin
        void'(qpos.pop_front());
        void'(qdat.pop_front());
      end
      if (pair_valid && (line_first || m_open)) begin
        idx = line_first ? 1 : m_pcnt + 1;
        m_pcnt = idx;
        m_open = (idx != 2545);
        if (line_first) for (int k = 0; k < 6; k++) m_sum[k] = 0;
        if (idx >= 12 && idx <= 36)
          for (int c = 0; c < 3; c++) begin
            m_sum[c]   += int'(odd_in[c*12 +: 12]);
            m_sum[c+3] += int'(even_in[c*12 +: 12]);
          end
        qpos.push_back(2 * idx - 1); qdat.push_back(odd_in);
        qpos.push_back(2 * idx);     qdat.push_back(even_in);
        if (idx == 2545)
          for (int k = 0; k < 6; k++) m_avg[k] = (2 * m_sum[k] + 25) / 50;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int p, etag, eidx;
      if (line_err) err_cnt++;
      chk(pix_valid == (qpos.size() > 0), "R1/R6 pix_valid", pix_valid, qpos.size() > 0);
      if (qpos.size() > 0) begin
        p = qpos[0];
        etag = (p >= 91) ? 2 : ((p >= 25 && p <= 66) ? 1 : 0);
        eidx = (p >= 91) ? p - 91 : 0;
        chk(pix_data == qdat[0], "R2 pix_data", pix_data, qdat[0]);
        chk(pix_tag == etag, "R3 pix_tag", pix_tag, etag);
        chk(pix_idx == eidx, "R4 pix_idx", pix_idx, eidx);
        chk(pix_sol == (p == 91), "R5 pix_sol", pix_sol, p == 91);
        chk(pix_eol == (p == 5090), "R5 pix_eol", pix_eol, p == 5090);
      end else begin
        chk(!pix_sol && !pix_eol, "R5 strobes idle", {pix_sol, pix_eol}, 0);
      end
      for (int c = 0; c < 3; c++) begin
        chk(blk_odd[c*12 +: 12] == m_avg[c], "R7/R8 blk_odd", blk_odd[c*12 +: 12], m_avg[c]);
        chk(blk_even[c*12 +: 12] == m_avg[c+3], "R7/R8 blk_even", blk_even[c*12 +: 12], m_avg[c+3]);
      end
      chk(line_err == m_err, "R9 line_err", line_err, m_err);
    end
  end

  task automatic send_pair(bit first, int seed, int p);
    @(negedge clk);
    pair_valid = 1'b1;
    line_first = first;
    for (int c = 0; c < 3; c++) begin
      odd_in[c*12 +: 12]  = smp(seed, c, 0, p);
      even_in[c*12 +: 12] = smp(seed, c, 1, p);
    end
    @(negedge clk);
    pair_valid = 1'b0;
    line_first = 1'b0;
  endtask

  task automatic send_line(int seed, int npairs, bit gaps);
    for (int p = 1; p <= npairs; p++) begin
      send_pair(p == 1, seed, p);
      if (gaps && (p % 3 == 0)) @(negedge clk);
    end
  endtask

  function automatic int ref_avg(int seed, int c, int par);
    int s = 0;
    for (int p = 12; p <= 36; p++) s += int'(smp(seed, c, par, p));
    return (2 * s + 25) / 50;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(pix_valid == 0 && pix_sol == 0 && pix_eol == 0, "R10 outputs in reset", pix_valid, 0);
    chk(line_err == 0, "R10 line_err in reset", line_err, 0);
    chk(blk_odd == 0 && blk_even == 0, "R10 averages in reset", blk_odd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 0, "R10 pix_valid after reset", pix_valid, 0);
    // R6: stray pairs before any line
    for (int i = 0; i < 4; i++) send_pair(1'b0, 7, i + 5);
    repeat (3) @(negedge clk);
    chk(pix_valid == 0, "R6 stray pairs ignored", pix_valid, 0);
    // back-to-back line
    send_line(1, 2545, 1'b0);
    repeat (3) @(negedge clk);
    chk(blk_odd[11:0] == ref_avg(1, 0, 0), "R7 red odd average", blk_odd[11:0], ref_avg(1, 0, 0));
    chk(blk_even[35:24] == ref_avg(1, 2, 1), "R7 blue even average", blk_even[35:24], ref_avg(1, 2, 1));
    chk(err_cnt == 0, "R9 no error on first line", err_cnt, 0);
    // R6: pairs after a completed line
    for (int i = 0; i < 3; i++) send_pair(1'b0, 8, i + 1);
    repeat (3) @(negedge clk);
    chk(pix_valid == 0, "R6 pairs after full line ignored", pix_valid, 0);
    // short line, then a gapped full line
    send_line(2, 1000, 1'b0);
    send_line(3, 2545, 1'b1);
    repeat (3) @(negedge clk);
    chk(err_cnt == 1, "R9 one short-line error", err_cnt, 1);
    chk(blk_green_ok(), "R7 green odd after gapped line", blk_odd[23:12], ref_avg(3, 1, 0));
    // saturated line
    send_line(99, 2545, 1'b0);
    repeat (3) @(negedge clk);
    chk(blk_odd == {3{12'hFFF}}, "R7 all-ones average", blk_odd, {3{12'hFFF}});
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit blk_green_ok();
    return blk_odd[23:12] == ref_avg(3, 1, 0);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule